// File: doc/BRIEF.md
# Sampled XOR Phase Meter

This block measures the phase offset between a reference square wave and a feedback square wave by sampling both with a fast system clock. It combines the two through an exclusive-OR. Over each reference period it counts how many clock samples fall in that period and how many of those samples have the XOR output high. The ratio of the two counts is the duty cycle of the XOR output, so it gives the phase difference directly. This digital measurement does the job an analog low-pass filter on the XOR output would otherwise do.

At every rising edge of the reference, the block latches both counts and raises a one-clock valid strobe. A lock flag reports whether the loop sits at the quadrature point. That point is a high count within a programmable tolerance of half the period count. A programmable sample limit marks a missing or stalled reference. A window that reaches the limit saturates and is never reported as valid. The inputs must be near-50% duty square waves. The response is linear from 0 to 180 degrees and folds back beyond that.

Top module: `xor_phase_meter`

## Requirements
- R1: While reset is asserted and after its release, before any reference edge has been seen, `period_cnt` and `high_cnt` read 0 and `meas_valid` and `quad_lock` are low.
- R2: For a reference with a steady period of P clock samples (P below `timeout_lim`), each rising reference edge after the first produces a one-clock `meas_valid` pulse with `period_cnt` = P. No two valid pulses are adjacent.
- R3: When the feedback is exactly in phase with the reference, `high_cnt` = 0.
- R4: With the feedback delayed by d samples and 0 < d <= P/2, `high_cnt` = 2d, which counts two XOR pulses per period. At d = P/2 (180 degrees), `high_cnt` equals `period_cnt`. `high_cnt` never exceeds `period_cnt` on a valid pulse.
- R5: With P/2 < d <= P, the reading folds back to `high_cnt` = 2(P - d), so a delay of a full period reads 0.
- R6: The first rising reference edge after reset only opens a window. It produces no valid pulse.
- R7: `quad_lock` is updated on each valid pulse to |2*`high_cnt` - `period_cnt`| <= 2*`lock_tol`. It holds that value until the next reference edge.
- R8: A window that reaches `timeout_lim` samples without a reference edge is stale. Its counter saturates at `timeout_lim`, `quad_lock` clears, no valid pulse is produced, and the edge that closes it loads `period_cnt` with `timeout_lim`. A reference period of exactly `timeout_lim` samples is therefore never valid.
- R9: After a stale window, the next complete window shorter than `timeout_lim` is reported as valid with correct counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_in | input | 1 | Reference square wave, asynchronous |
| fb_in | input | 1 | Feedback square wave, asynchronous |
| lock_tol | input | CNT_W | Allowed distance of the high count from half the period |
| timeout_lim | input | CNT_W | Sample count at which a window becomes stale (at least 2) |
| period_cnt | output | CNT_W | Samples in the last closed window |
| high_cnt | output | CNT_W | Samples with differing inputs in that window |
| meas_valid | output | 1 | One-clock strobe: the counts describe a complete window |
| quad_lock | output | 1 | Loop is within tolerance of 90 degrees |

## Verification
A window counter that starts one sample off, or that fails to clear at an edge, would show at the very next valid pulse. It would appear either as a period count differing from the driven period or as a high count differing from twice the folded delay. A state that stays in the stale or idle condition would suppress the valid strobe for a whole reference period or longer. A stale window that is wrongly treated as complete would raise the strobe within one period of the stall. The sweep covers every sample delay across a full period at two period lengths, so errors in the fold and the 180 degree end show at the first checked window of the affected delay.

// File: rtl/xpm_pkg.sv
// Shared definitions for the sampled XOR phase meter.
package xpm_pkg;
    // Default synchronizer depth for asynchronous inputs.
    localparam int unsigned SYNC_DEPTH_DEF = 2;

    // Measurement window state.
    typedef enum logic [1:0] {
        WIN_IDLE  = 2'd0,   // no reference edge seen yet
        WIN_RUN   = 2'd1,   // counting a live window
        WIN_STALE = 2'd2    // window hit the sample limit
    } win_state_e;
endpackage

// File: rtl/xpm_sync.sv
// Multi-stage synchronizer, one flop chain per lane.
// Assumes each lane is an independent level; no cross-lane coherence.
module xpm_sync #(
    parameter int unsigned LANES  = 2,
    parameter int unsigned STAGES = xpm_pkg::SYNC_DEPTH_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] async_i,
    output logic [LANES-1:0] sync_o
);
    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            logic [STAGES-1:0] chain_q;
            // Shift the raw level through the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], async_i[g]};
            end
            assign sync_o[g] = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/xpm_window.sv
// Window counter: detects rising reference edges, counts samples and
// XOR-high samples between them, latches results and flags stale windows.
// Assumes lim_i >= 2 and is held steady while a window runs.
module xpm_window #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_s_i,
    input  logic             diff_i,
    input  logic [CNT_W-1:0] lim_i,
    output logic             rise_o,
    output logic             win_ok_o,
    output logic             stale_o,
    output logic [CNT_W-1:0] per_live_o,
    output logic [CNT_W-1:0] hi_live_o,
    output logic             valid_o,
    output logic [CNT_W-1:0] period_o,
    output logic [CNT_W-1:0] high_o
);
    import xpm_pkg::*;

    localparam int unsigned EXT_W = CNT_W + 1;

    win_state_e       state_q;
    logic             ref_d_q;
    logic [CNT_W-1:0] per_q;
    logic [CNT_W-1:0] hi_q;
    logic [EXT_W-1:0] per_nxt;
    logic             hits_lim;

    assign rise_o     = ref_s_i & ~ref_d_q;
    assign win_ok_o   = rise_o && (state_q == WIN_RUN);
    assign stale_o    = (state_q == WIN_STALE);
    assign per_live_o = per_q;
    assign hi_live_o  = hi_q;
    assign per_nxt    = {1'b0, per_q} + EXT_W'(1);
    assign hits_lim   = (per_nxt >= {1'b0, lim_i});

    // Delay the synchronized reference for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ref_d_q <= 1'b0;
        else        ref_d_q <= ref_s_i;
    end

    // Advance the window state at edges and on reaching the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                              state_q <= WIN_IDLE;
        else if (rise_o)                         state_q <= WIN_RUN;
        else if (state_q == WIN_RUN && hits_lim) state_q <= WIN_STALE;
    end

    // Count samples and XOR-high samples of the live window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q <= '0;
            hi_q  <= '0;
        end else if (rise_o) begin
            per_q <= CNT_W'(1);
            hi_q  <= diff_i ? CNT_W'(1) : '0;
        end else if (state_q == WIN_RUN) begin
            per_q <= hits_lim ? lim_i : per_nxt[CNT_W-1:0];
            hi_q  <= hi_q + CNT_W'(diff_i);
        end
    end

    // Latch the closed window's counts and strobe completed ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_o <= '0;
            high_o   <= '0;
            valid_o  <= 1'b0;
        end else begin
            valid_o <= win_ok_o;
            if (rise_o && state_q != WIN_IDLE) begin
                period_o <= per_q;
                high_o   <= hi_q;
            end
        end
    end

    // R2: strobes come from distinct edges, never back to back
    assert_valid_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R6/R8: a strobe only follows a window that was running cleanly
    assert_valid_from_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(state_q == WIN_RUN));

    // R8: a stale window holds its saturated count until an edge
    assert_stale_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WIN_STALE && !rise_o && $stable(lim_i)) |=> (per_q == $past(per_q)));
endmodule

// File: rtl/xpm_lock.sv
// Quadrature lock judge: compares twice the high count with the period
// count at each window close. Assumes counts come from the same window.
module xpm_lock #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_i,
    input  logic             win_ok_i,
    input  logic             stale_i,
    input  logic [CNT_W-1:0] per_i,
    input  logic [CNT_W-1:0] hi_i,
    input  logic [CNT_W-1:0] tol_i,
    output logic             lock_o
);
    localparam int unsigned DBL_W = CNT_W + 1;

    logic [DBL_W-1:0] hi_dbl;
    logic [DBL_W-1:0] per_ext;
    logic [DBL_W-1:0] gap;
    logic             near_quad;

    // Distance of the doubled high count from the period.
    always_comb begin
        hi_dbl    = {hi_i, 1'b0};
        per_ext   = {1'b0, per_i};
        gap       = (hi_dbl >= per_ext) ? (hi_dbl - per_ext) : (per_ext - hi_dbl);
        near_quad = (gap <= {tol_i, 1'b0});
    end

    // Update lock at window close, clear it while stale.
    always_ff @(posedge clk) begin
        if (!rst_n)      lock_o <= 1'b0;
        else if (stale_i) lock_o <= 1'b0;
        else if (rise_i)  lock_o <= win_ok_i && near_quad;
    end

    // R7: lock only rises at a completed window close
    assert_lock_on_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> $past(rise_i && win_ok_i));

    // R8: lock cannot be set while the window is stale
    assert_lock_clear_stale_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stale_i && !rise_i) |=> !lock_o);
endmodule

// File: rtl/xor_phase_meter.sv
// Sampled XOR phase meter top: synchronizes reference and feedback,
// forms their XOR and measures its duty per reference period.
// Assumes near-50% duty square inputs slower than a few clock periods.
module xor_phase_meter #(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned STAGES = xpm_pkg::SYNC_DEPTH_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_in,
    input  logic             fb_in,
    input  logic [CNT_W-1:0] lock_tol,
    input  logic [CNT_W-1:0] timeout_lim,
    output logic [CNT_W-1:0] period_cnt,
    output logic [CNT_W-1:0] high_cnt,
    output logic             meas_valid,
    output logic             quad_lock
);
    localparam int unsigned LANES = 2;

    logic [LANES-1:0] raw;
    logic [LANES-1:0] synced;
    logic             diff;
    logic             rise;
    logic             win_ok;
    logic             stale;
    logic [CNT_W-1:0] per_live;
    logic [CNT_W-1:0] hi_live;

    assign raw  = {fb_in, ref_in};
    assign diff = synced[0] ^ synced[1];

    xpm_sync #(.LANES(LANES), .STAGES(STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw),
        .sync_o  (synced)
    );

    xpm_window #(.CNT_W(CNT_W)) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_s_i    (synced[0]),
        .diff_i     (diff),
        .lim_i      (timeout_lim),
        .rise_o     (rise),
        .win_ok_o   (win_ok),
        .stale_o    (stale),
        .per_live_o (per_live),
        .hi_live_o  (hi_live),
        .valid_o    (meas_valid),
        .period_o   (period_cnt),
        .high_o     (high_cnt)
    );

    xpm_lock #(.CNT_W(CNT_W)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_i   (rise),
        .win_ok_i (win_ok),
        .stale_i  (stale),
        .per_i    (per_live),
        .hi_i     (hi_live),
        .tol_i    (lock_tol),
        .lock_o   (quad_lock)
    );

    // R4: a reported high count never exceeds its period count
    assert_high_le_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
        meas_valid |-> (high_cnt <= period_cnt));
endmodule

// File: tb/xor_phase_meter_tb.sv
`timescale 1ns/1ps
module xor_phase_meter_tb_top;
    localparam int W   = 8;
    localparam int LIM = 60;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ref_in = 1'b0;
    logic         fb_in = 1'b0;
    logic [W-1:0] lock_tol = W'(2);
    logic [W-1:0] timeout_lim = W'(LIM);
    logic [W-1:0] period_cnt;
    logic [W-1:0] high_cnt;
    logic         meas_valid;
    logic         quad_lock;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    xor_phase_meter #(.CNT_W(W)) dut_i (
        .clk (clk), .rst_n (rst_n), .ref_in (ref_in), .fb_in (fb_in),
        .lock_tol (lock_tol), .timeout_lim (timeout_lim),
        .period_cnt (period_cnt), .high_cnt (high_cnt),
        .meas_valid (meas_valid), .quad_lock (quad_lock)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one sample of a P-period reference and a d-delayed feedback.
    task automatic drive(input int p, input int d, input int k);
        @(negedge clk);
        ref_in = ((k % p) < p / 2);
        fb_in  = (((k + 2 * p - d) % p) < p / 2);
    endtask

    // Run nper periods; after skip strobes check counts and lock.
    task automatic run_case(input int p, input int d, input int nper, input int skip,
                            input string tag, output int late_valids);
        int seen = 0;
        int dm;
        int exp_hi;
        bit exp_lock;
        int gap;
        bit lock_known = 0;
        late_valids = 0;
        dm = d % p;
        exp_hi = (dm <= p / 2) ? 2 * dm : 2 * (p - dm);
        gap = 2 * exp_hi - p;
        if (gap < 0) gap = -gap;
        exp_lock = (gap <= 2 * int'(lock_tol));
        for (int k = 0; k < nper * p; k++) begin
            drive(p, d, k);
            if (meas_valid) begin
                seen++;
                if (k >= 2 * p) late_valids++;
                if (seen > skip) begin
                    chk(period_cnt == W'(p), {tag, " R2 period"}, int'(period_cnt), p);
                    chk(high_cnt == W'(exp_hi), tag, int'(high_cnt), exp_hi);
                    chk(quad_lock == exp_lock, "R7 lock at strobe", int'(quad_lock), int'(exp_lock));
                    lock_known = 1;
                end
            end else if (lock_known) begin
                chk(quad_lock == exp_lock, "R7 lock held", int'(quad_lock), int'(exp_lock));
            end
        end
    endtask

    initial begin
        #4_000_000;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int nv;
        int vcount;
        repeat (4) @(negedge clk);
        // R1: outputs cleared during reset
        chk(period_cnt == 0, "R1 period", int'(period_cnt), 0);
        chk(high_cnt == 0, "R1 high", int'(high_cnt), 0);
        chk(!meas_valid, "R1 valid", int'(meas_valid), 0);
        chk(!quad_lock, "R1 lock", int'(quad_lock), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(period_cnt == 0 && !meas_valid, "R1 after release", int'(meas_valid), 0);

        // R6: first reference edge produces no strobe
        vcount = 0;
        for (int k = 0; k < 22; k++) begin
            drive(20, 0, k);
            if (meas_valid) vcount++;
        end
        chk(vcount == 0, "R6 no strobe on first edge", vcount, 0);

        // Full delay sweeps at two period lengths.
        for (int d = 0; d <= 40; d++)
            run_case(40, d, 5, 2,
                     (d == 0 || d == 40) ? "R3 in phase" : (d <= 20 ? "R4 delay" : "R5 fold"), nv);
        for (int d = 0; d <= 20; d++)
            run_case(20, d, 5, 2,
                     (d == 0 || d == 20) ? "R3 in phase" : (d <= 10 ? "R4 delay" : "R5 fold"), nv);

        // R7: tolerance boundary with zero tolerance.
        lock_tol = W'(0);
        run_case(40, 9, 4, 2, "R7 tol0 off", nv);
        run_case(40, 10, 4, 2, "R7 tol0 on", nv);
        lock_tol = W'(2);
        run_case(40, 10, 4, 2, "R7 tol2 on", nv);
        chk(quad_lock, "R7 lock before stall", int'(quad_lock), 1);

        // R8: stall the reference past the limit.
        vcount = 0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            ref_in = 1'b0;
            fb_in  = 1'b0;
            if (meas_valid) vcount++;
        end
        chk(vcount == 0, "R8 no strobe while stalled", vcount, 0);
        chk(!quad_lock, "R8 lock cleared", int'(quad_lock), 0);
        vcount = 0;
        for (int k = 0; k < 40; k++) begin
            drive(40, 10, k);
            if (meas_valid) vcount++;
            if (k == 30)
                chk(period_cnt == W'(LIM), "R8 saturated period", int'(period_cnt), LIM);
        end
        chk(vcount == 0, "R8 stale close not valid", vcount, 0);
        // R9: next clean window valid again
        run_case(40, 10, 3, 0, "R9 recovery", nv);
        chk(nv >= 1, "R9 strobes after recovery", nv, 1);

        // R8: period equal to the limit never valid; just below is valid.
        run_case(LIM, 0, 5, 2, "R8 at limit", nv);
        chk(nv == 0, "R8 period at limit", nv, 0);
        run_case(LIM - 2, 14, 5, 2, "R4 below limit", nv);
        chk(nv >= 1, "R9 period below limit", nv, 1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule